// File: doc/BRIEF.md
# Checkpoint Replay Recovery Controller

This controller sequences recovery for a pipeline whose timing-error flip-flops only report errors and never repair state. Retired results first pass through a chain of stabilization registers. Only after that do they become the committed checkpoint, which holds the register bank, the program counter and the status register. The controller drives the write strobe for that checkpoint and presents the PC being written. The checkpoint storage and the pipeline datapath sit outside the block.

When any error flag is seen through a two-flop synchronizer, the controller:
- flushes the pipeline for a fixed number of cycles;
- pulses a restore strobe for one cycle while presenting the checkpoint PC;
- enters replay.

Each error with no checkpoint write since the previous error counts as another failure of the same restart PC. Once that count reaches the limit, the clock-halving request is raised. It stays high until the next checkpoint write, which proves that the stuck instruction has committed. That write also clears the count.

The field `commit_pc` is the address at which execution resumes once the retiring instruction is in the checkpoint.

Top module: `replay_recovery_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, flush, restore, half_speed, ckpt_we and in_replay are 0 and restart_pc equals RESET_PC.
- R2: A commit_valid sampled at a clock edge in run or replay, with no error pending, raises ckpt_we with ckpt_wpc equal to its commit_pc exactly STAB edges later. restart_pc takes that value one edge after that. Commits on consecutive cycles are each written in order.
- R3: An err_in bit that is high at one clock edge makes flush rise at the third edge after it. flush then stays high for FLUSH_LEN cycles.
- R4: restore is high for exactly the one cycle that follows the last flush cycle, and restart_pc holds the checkpoint PC during it. in_replay is high from the next cycle onward.
- R5: commit_valid offered while flush or restore is high is dropped: it never produces ckpt_we, and restart_pc keeps its value.
- R6: A commit that is still in the stabilization stages when a synchronized error arrives is discarded and never written to the checkpoint.
- R7: half_speed rises in the same cycle as flush when this error brings the count of consecutive errors without a checkpoint write to FAIL_LIMIT. It stays high through flush, restore and replay, and further errors keep it high. Fewer errors leave it low.
- R8: The first checkpoint write after recovery clears half_speed and in_replay on the following edge and resets the failure count to zero.
- R9: Each err_in bit on its own starts the recovery sequence.
- R10: flush and restore are never high together, and restart_pc changes only on the edge right after a cycle with ckpt_we high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_in | input | NERR | Asynchronous timing-error flags from the detecting flip-flops |
| commit_valid | input | 1 | An instruction retires from the pipeline this cycle |
| commit_pc | input | PCW | Resume address after the retiring instruction |
| flush | output | 1 | Flush the pipeline |
| restore | output | 1 | Load architectural state from the checkpoint |
| restart_pc | output | PCW | PC held in the committed checkpoint |
| ckpt_we | output | 1 | Write the stabilized result into the checkpoint this cycle |
| ckpt_wpc | output | PCW | PC being written into the checkpoint |
| half_speed | output | 1 | Request half clock frequency |
| in_replay | output | 1 | Re-executing from the checkpoint, no write yet |

## Verification
The bench counts edges from each error pulse. A synchronizer that is one stage short or one stage long moves the start of flush by one cycle, and an off-by-one in the flush counter stretches or shortens recovery.

It also offers a commit together with an error, and more commits during flush and restore. A design that let these through would write a checkpoint for a result that never really retired, and restart_pc would move.

It then replays errors with no commit between them. A counter that fails to saturate, fails to clear, or compares against the wrong bound raises half speed one error too early or too late. It would also hold half speed after the stuck instruction has finally committed.

// File: rtl/replay_recovery_ctrl.sv
module replay_recovery_ctrl #(
  parameter int unsigned NERR       = 4,
  parameter int unsigned PCW        = 16,
  parameter int unsigned STAB       = 2,
  parameter int unsigned FLUSH_LEN  = 2,
  parameter int unsigned FAIL_LIMIT = 2,
  parameter int unsigned RESET_PC   = 'h100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NERR-1:0] err_in,
  input  logic            commit_valid,
  input  logic [PCW-1:0]  commit_pc,
  output logic            flush,
  output logic            restore,
  output logic [PCW-1:0]  restart_pc,
  output logic            ckpt_we,
  output logic [PCW-1:0]  ckpt_wpc,
  output logic            half_speed,
  output logic            in_replay
);

  localparam int unsigned CW = $clog2(FAIL_LIMIT + 1);
  localparam int unsigned FW = (FLUSH_LEN > 1) ? $clog2(FLUSH_LEN) : 1;

  typedef enum logic [1:0] {S_RUN, S_FLUSH, S_RESTORE, S_REPLAY} st_t;

  st_t             st;
  logic [NERR-1:0] sy1, sy2;
  logic [STAB-1:0] pv;
  logic [PCW-1:0]  ppc [STAB];
  logic [CW-1:0]   fails;
  logic [FW-1:0]   fcnt;
  logic [PCW-1:0]  ckpt;

  wire err_det   = |sy2;
  wire accepting = (st == S_RUN) || (st == S_REPLAY);
  wire take      = accepting && !err_det;
  wire [CW-1:0] fails_nx = (fails == CW'(FAIL_LIMIT)) ? fails : fails + CW'(1);

  assign flush      = (st == S_FLUSH);
  assign restore    = (st == S_RESTORE);
  assign in_replay  = (st == S_REPLAY);
  assign ckpt_we    = take && pv[STAB-1];
  assign ckpt_wpc   = ppc[STAB-1];
  assign restart_pc = ckpt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= err_in;
      sy2 <= sy1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0;
    end else if (!take) begin
      pv <= '0;
    end else begin
      pv[0] <= commit_valid;
      for (int i = 1; i < int'(STAB); i++) pv[i] <= pv[i-1];
    end
  end

  always_ff @(posedge clk) begin
    ppc[0] <= commit_pc;
    for (int i = 1; i < int'(STAB); i++) ppc[i] <= ppc[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_RUN;
      fcnt       <= '0;
      fails      <= '0;
      half_speed <= 1'b0;
      ckpt       <= PCW'(RESET_PC);
    end else begin
      case (st)
        S_RUN, S_REPLAY: begin
          if (err_det) begin
            st         <= S_FLUSH;
            fcnt       <= '0;
            fails      <= fails_nx;
            half_speed <= (fails_nx == CW'(FAIL_LIMIT));
          end else if (ckpt_we) begin
            ckpt       <= ckpt_wpc;
            fails      <= '0;
            half_speed <= 1'b0;
            st         <= S_RUN;
          end
        end
        S_FLUSH: begin
          if (fcnt == FW'(FLUSH_LEN - 1)) st <= S_RESTORE;
          else fcnt <= fcnt + FW'(1);
        end
        S_RESTORE: st <= S_REPLAY;
        default:   st <= S_RUN;
      endcase
    end
  end

endmodule

// File: rtl/replay_recovery_ctrl_chk.sv
module replay_recovery_ctrl_chk #(
  parameter int unsigned NERR = 4,
  parameter int unsigned PCW  = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NERR-1:0] err_in,
  input logic            flush,
  input logic            restore,
  input logic [PCW-1:0]  restart_pc,
  input logic            ckpt_we,
  input logic [PCW-1:0]  ckpt_wpc,
  input logic            half_speed,
  input logic            in_replay
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush && restore));

  a_r4_restore_follows_flush: assert property (@(posedge clk) disable iff (!rst_n || age == 2'd0)
    restore |-> $past(flush));

  a_r4_replay_after_restore: assert property (@(posedge clk) disable iff (!rst_n || age == 2'd0)
    $fell(restore) |-> in_replay);

  a_r3_flush_cause: assert property (@(posedge clk) disable iff (!rst_n || age != 2'd3)
    $rose(flush) |-> $past(|err_in, 3));

  a_r2_ckpt_load: assert property (@(posedge clk) disable iff (!rst_n || age == 2'd0)
    $past(ckpt_we) |-> restart_pc == $past(ckpt_wpc));

  a_r10_pc_hold: assert property (@(posedge clk) disable iff (!rst_n || age == 2'd0)
    !$past(ckpt_we) |-> $stable(restart_pc));

  a_r5_no_write_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    (flush || restore) |-> !ckpt_we);

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_we |=> (!half_speed && !in_replay));

  a_r7_half_with_flush: assert property (@(posedge clk) disable iff (!rst_n || age == 2'd0)
    $rose(half_speed) |-> $rose(flush));

endmodule

bind replay_recovery_ctrl replay_recovery_ctrl_chk #(.NERR(NERR), .PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_in(err_in), .flush(flush), .restore(restore),
  .restart_pc(restart_pc), .ckpt_we(ckpt_we), .ckpt_wpc(ckpt_wpc),
  .half_speed(half_speed), .in_replay(in_replay)
);

// File: tb/replay_recovery_ctrl_bench.sv
module replay_recovery_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NERR = 4;
  localparam int PCW = 16;
  localparam int STAB = 2;
  localparam int FLUSH_LEN = 2;
  localparam int LIMIT = 2;
  localparam int RPC = 'h100;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NERR-1:0] err_in = '0;
  logic commit_valid = 1'b0;
  logic [PCW-1:0] commit_pc = '0;
  logic flush, restore, ckpt_we, half_speed, in_replay;
  logic [PCW-1:0] restart_pc, ckpt_wpc;

  int checks = 0;
  int errors = 0;
  int fails = 0;
  logic [PCW-1:0] exp_ckpt = PCW'(RPC);

  always #(CLK_PERIOD/2) clk = ~clk;

  replay_recovery_ctrl #(.NERR(NERR), .PCW(PCW), .STAB(STAB), .FLUSH_LEN(FLUSH_LEN),
    .FAIL_LIMIT(LIMIT), .RESET_PC(RPC)) u_replay_recovery_ctrl (
    .clk(clk), .rst_n(rst_n), .err_in(err_in), .commit_valid(commit_valid),
    .commit_pc(commit_pc), .flush(flush), .restore(restore), .restart_pc(restart_pc),
    .ckpt_we(ckpt_we), .ckpt_wpc(ckpt_wpc), .half_speed(half_speed), .in_replay(in_replay));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic commit_one(input logic [PCW-1:0] pc);
    commit_valid = 1'b1; commit_pc = pc;
    tick();
    commit_valid = 1'b0;
    tick();
    chk("R2 ckpt_we", {31'b0, ckpt_we}, 1);
    chk("R2 ckpt_wpc", {16'b0, ckpt_wpc}, {16'b0, pc});
    tick();
    exp_ckpt = pc; fails = 0;
    chk("R2 restart_pc", {16'b0, restart_pc}, {16'b0, pc});
    chk("R8 half_speed cleared", {31'b0, half_speed}, 0);
    chk("R8 in_replay cleared", {31'b0, in_replay}, 0);
  endtask

  // mode 0: plain error, 1: commit with error (R6), 2: commits during flush/restore (R5)
  task automatic err_one(input logic [NERR-1:0] bits, input int mode, input logic [PCW-1:0] pc);
    logic eh;
    fails = (fails < LIMIT) ? fails + 1 : fails;
    eh = (fails >= LIMIT);
    err_in = bits;
    if (mode == 1) begin commit_valid = 1'b1; commit_pc = pc; end
    tick();
    err_in = '0; commit_valid = 1'b0;
    chk("R3 no early flush", {31'b0, flush}, 0);
    tick();
    chk("R3 no early flush", {31'b0, flush}, 0);
    chk("R6 discarded commit", {31'b0, ckpt_we}, 0);
    tick();
    chk("R3 flush rises", {31'b0, flush}, 1);
    chk("R9 flush per bit", {31'b0, flush}, 1);
    chk("R7 half_speed", {31'b0, half_speed}, {31'b0, eh});
    if (mode == 2) begin commit_valid = 1'b1; commit_pc = pc; end
    tick();
    chk("R3 flush held", {31'b0, flush}, 1);
    chk("R5 no write in flush", {31'b0, ckpt_we}, 0);
    if (mode == 2) commit_pc = pc + 16'd4;
    tick();
    commit_valid = 1'b0;
    chk("R4 restore", {31'b0, restore}, 1);
    chk("R4 flush ended", {31'b0, flush}, 0);
    chk("R4 restart_pc", {16'b0, restart_pc}, {16'b0, exp_ckpt});
    chk("R7 half_speed held", {31'b0, half_speed}, {31'b0, eh});
    tick();
    chk("R4 in_replay", {31'b0, in_replay}, 1);
    chk("R4 restore one cycle", {31'b0, restore}, 0);
    for (int i = 0; i < 3; i++) begin
      chk("R5 R6 no write", {31'b0, ckpt_we}, 0);
      tick();
    end
    chk("R5 R6 restart_pc kept", {16'b0, restart_pc}, {16'b0, exp_ckpt});
    chk("R7 half_speed in replay", {31'b0, half_speed}, {31'b0, eh});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 restart_pc in reset", {16'b0, restart_pc}, RPC);
    chk("R1 flush in reset", {31'b0, flush}, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 flush", {31'b0, flush}, 0);
    chk("R1 restore", {31'b0, restore}, 0);
    chk("R1 half_speed", {31'b0, half_speed}, 0);
    chk("R1 ckpt_we", {31'b0, ckpt_we}, 0);
    chk("R1 in_replay", {31'b0, in_replay}, 0);
    chk("R1 restart_pc", {16'b0, restart_pc}, RPC);

    // R2: back-to-back commits
    for (int i = 0; i < 8; i++) begin
      if (i >= STAB && i - STAB < 5) begin
        chk("R2 burst ckpt_we", {31'b0, ckpt_we}, 1);
        chk("R2 burst ckpt_wpc", {16'b0, ckpt_wpc}, 'h200 + 4 * (i - STAB));
      end
      if (i >= STAB + 1 && i - STAB - 1 < 5)
        chk("R2 burst restart_pc", {16'b0, restart_pc}, 'h200 + 4 * (i - STAB - 1));
      commit_valid = (i < 5);
      commit_pc = PCW'('h200 + 4 * i);
      tick();
    end
    commit_valid = 1'b0;
    tick();
    exp_ckpt = PCW'('h210);
    chk("R2 burst final", {16'b0, restart_pc}, {16'b0, exp_ckpt});

    // R9: every error bit alone, each followed by a clean commit
    for (int b = 0; b < NERR; b++) begin
      err_one(NERR'(1) << b, 0, '0);
      commit_one(PCW'('h300 + 4 * b));
    end

    // R7: consecutive failures, saturation, then release
    for (int k = 0; k < 4; k++) err_one(4'b0010, 0, '0);
    commit_one(PCW'('h400));
    err_one(4'b0001, 0, '0);
    commit_one(PCW'('h404));

    // R6: commit in flight when error arrives
    err_one(4'b0100, 1, PCW'('h500));
    // R5: commits during flush and restore, now second failure
    err_one(4'b1000, 2, PCW'('h600));
    commit_one(PCW'('h700));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule